// File: doc/BRIEF.md
# Privilege-Ring Call-Gate Sequencer

This block carries out a far call through a gate descriptor. On a start pulse it takes a gate selector and the caller's code segment, return offset, stack segment and stack pointer. It fetches the gate from a descriptor table and checks it. If the gate is valid, the block builds a call frame in memory and hands back the register values the callee starts with. If the gate is refused, it raises a fault and leaves its result registers as they were.

When the gate leads to a more trusted ring, the block first reads that ring's stack segment and stack pointer from a task-state block. It then saves the caller's stack location on the new stack and copies the number of argument words that the gate specifies from the old stack. Last, it pushes the return linkage. A gate into the caller's own ring pushes only the return linkage, on the caller's stack. All traffic goes through one single-port memory of 16-bit words addressed by byte. Reads return their data one cycle after the request.

Top module: `cg_call_gate`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `mem_req` are 0 and all four result outputs are 0.
- R2: The three gate words are read, in this order, at byte addresses `gdt_base + 8*gate_sel[15:3] + 0`, `+2` and `+4`. Word 0 is the entry offset and word 1 is the target code selector. Word 2 holds: bits 4:0 the argument count, bits 11:8 the type, bits 14:13 the gate ring, bit 15 present.
- R3: The call is refused when any of these holds: the present bit is 0, the type is not 4, the caller ring `cur_cs[1:0]` is numerically greater than the gate ring, or the target ring (`selector[1:0]` of word 1) is numerically greater than the caller ring. A refused call writes no memory, pulses `done` with `fault`=1 and leaves all result outputs unchanged.
- R4: When the target ring equals the caller ring, only `cur_cs` and then `cur_ip` are pushed, on the caller's stack. No argument words are copied. `new_ss`=`cur_ss` and `new_sp`=`cur_sp`-4.
- R5: For a more trusted target ring r, the new stack pointer is read at `tss_base+2+4r` and then the new stack segment at `tss_base+4+4r`.
- R6: On a ring change the pushes go in this order: old SS, old SP, the argument words, old CS, return IP. Each push first lowers SP by 2 and then writes at `16*SS + SP`, truncated to 20 bits.
- R7: The argument count n is word 2 bits 4:0 (0 to 31). The words are read from old-stack offsets `cur_sp+2(n-1)` down to `cur_sp`, each read followed by its push, so their order is kept.
- R8: On success, `new_cs` is word 1, `new_ip` is word 0, `new_ss` is the stack segment in use and `new_sp` is its final pointer.
- R9: `done` is a one-cycle pulse. `busy` is high from the cycle after an accepted start through the `done` cycle. `start` is ignored while `busy` is high. No memory request is made while idle.
- R10: Counting clock edges after the edge that samples `start`, `done` shows after 7 edges for a refused call, 9 for a same-ring call and 15+3n for a ring change.
- R11: A gate of type 0xC (the wide form) is refused like any other non-4 type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | begin a call (taken when idle) |
| gate_sel | input | 16 | gate selector |
| cur_cs | input | 16 | caller code segment (low 2 bits: ring) |
| cur_ip | input | 16 | offset of the instruction after the call |
| cur_ss | input | 16 | caller stack segment |
| cur_sp | input | 16 | caller stack pointer |
| gdt_base | input | 20 | descriptor table base byte address |
| tss_base | input | 20 | task-state block base byte address |
| mem_req | output | 1 | memory access this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 20 | byte address of the word |
| mem_wdata | output | 16 | write data |
| mem_rdata | input | 16 | read data, valid the cycle after a read request |
| busy | output | 1 | call in progress |
| done | output | 1 | call finished (one cycle) |
| fault | output | 1 | call refused, valid with done |
| new_cs | output | 16 | callee code segment |
| new_ip | output | 16 | callee entry offset |
| new_ss | output | 16 | callee stack segment |
| new_sp | output | 16 | callee stack pointer |

## Verification
The hardest case to reach from the ports is a long argument copy from an unprivileged ring. It needs a gate, a task-state slot and a filled old stack that all agree, and the copy is only right if every read address and push address steps correctly across up to 31 iterations. The bench builds these structures in its memory model and places a distinct value in every old-stack word. It predicts the exact sequence of memory accesses from the requirements and compares each access in the cycle it is made. It also fires a second start in the middle of a call to show that it has no effect. Refusals are tried one cause at a time, including the equality boundary of the ring comparison.

// File: rtl/cg_pkg.sv
package cg_pkg;
    parameter int AW        = 20;
    parameter int WW        = 16;
    parameter int CW        = 5;
    parameter int SEG_SHIFT = 4;

    localparam int STEP            = WW / 8;
    localparam int DESC_BYTES      = 4 * STEP;
    localparam logic [3:0] KIND_GATE16 = 4'h4;

    typedef logic [AW-1:0] addr_t;
    typedef logic [WW-1:0] word_t;
    typedef logic [1:0]    ring_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DESC,
        S_CHECK,
        S_TSP,
        S_TSS,
        S_PUSH_OSS,
        S_PUSH_OSP,
        S_PREAD,
        S_PWRITE,
        S_PUSH_CS,
        S_PUSH_IP,
        S_FIN
    } st_e;

    typedef enum logic [1:0] {
        F_NONE,
        F_ABSENT,
        F_KIND,
        F_PRIV
    } flt_e;

    typedef struct packed {
        word_t           entry;
        word_t           csel;
        logic            present;
        ring_t           dpl;
        logic [3:0]      kind;
        logic [CW-1:0]   count;
    } gate_t;

    typedef struct packed {
        addr_t         gbase;
        addr_t         tbase;
        word_t         sel;
        word_t         ocs;
        word_t         oip;
        word_t         oss;
        word_t         osp;
        word_t         nss;
        word_t         nsp;
        word_t         tmp;
        ring_t         tgt;
        logic [CW-1:0] pcnt;
    } ctx_t;

    function automatic addr_t lin_addr(word_t seg, word_t off);
        return (addr_t'(seg) << SEG_SHIFT) + addr_t'(off);
    endfunction

    function automatic addr_t tss_slot(addr_t base, ring_t r, logic want_ss);
        addr_t a;
        a = base + addr_t'(STEP) + addr_t'(r) * addr_t'(2 * STEP);
        if (want_ss)
            a = a + addr_t'(STEP);
        return a;
    endfunction

    function automatic addr_t desc_addr(addr_t base, word_t sel, logic [1:0] widx);
        return base + addr_t'(sel & ~word_t'(DESC_BYTES - 1)) + addr_t'(widx) * addr_t'(STEP);
    endfunction
endpackage

// File: rtl/cg_gate_check.sv
module cg_gate_check
    import cg_pkg::*;
(
    input  logic       present,
    input  ring_t      dpl,
    input  logic [3:0] kind,
    input  ring_t      tgt,
    input  ring_t      cpl,
    output flt_e       flt,
    output logic       do_switch
);
    always_comb begin
        do_switch = (tgt < cpl);
        if (!present)
            flt = F_ABSENT;
        else if (kind != KIND_GATE16)
            flt = F_KIND;
        else if ((cpl > dpl) || (tgt > cpl))
            flt = F_PRIV;
        else
            flt = F_NONE;
    end
endmodule

// File: rtl/cg_mem_drive.sv
module cg_mem_drive
    import cg_pkg::*;
(
    input  st_e        st,
    input  logic       ph,
    input  logic [1:0] widx,
    input  ctx_t       cx,
    output logic       req,
    output logic       we,
    output addr_t      addr,
    output word_t      wdata
);
    logic [CW-1:0] pm1;
    addr_t         push_a;

    always_comb begin
        pm1    = cx.pcnt - 1'b1;
        push_a = lin_addr(cx.nss, cx.nsp - word_t'(STEP));
        req    = 1'b0;
        we     = 1'b0;
        addr   = '0;
        wdata  = '0;
        unique case (st)
            S_DESC: begin
                req  = !ph;
                addr = desc_addr(cx.gbase, cx.sel, widx);
            end
            S_TSP: begin
                req  = !ph;
                addr = tss_slot(cx.tbase, cx.tgt, 1'b0);
            end
            S_TSS: begin
                req  = !ph;
                addr = tss_slot(cx.tbase, cx.tgt, 1'b1);
            end
            S_PREAD: begin
                req  = !ph;
                addr = lin_addr(cx.oss, cx.osp + word_t'(pm1) * word_t'(STEP));
            end
            S_PUSH_OSS: begin
                req = 1'b1; we = 1'b1; addr = push_a; wdata = cx.oss;
            end
            S_PUSH_OSP: begin
                req = 1'b1; we = 1'b1; addr = push_a; wdata = cx.osp;
            end
            S_PWRITE: begin
                req = 1'b1; we = 1'b1; addr = push_a; wdata = cx.tmp;
            end
            S_PUSH_CS: begin
                req = 1'b1; we = 1'b1; addr = push_a; wdata = cx.ocs;
            end
            S_PUSH_IP: begin
                req = 1'b1; we = 1'b1; addr = push_a; wdata = cx.oip;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cg_call_gate.sv
module cg_call_gate
    import cg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [15:0]   gate_sel,
    input  logic [15:0]   cur_cs,
    input  logic [15:0]   cur_ip,
    input  logic [15:0]   cur_ss,
    input  logic [15:0]   cur_sp,
    input  logic [19:0]   gdt_base,
    input  logic [19:0]   tss_base,
    output logic          mem_req,
    output logic          mem_we,
    output logic [19:0]   mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          fault,
    output logic [15:0]   new_cs,
    output logic [15:0]   new_ip,
    output logic [15:0]   new_ss,
    output logic [15:0]   new_sp
);
    st_e        st;
    logic       ph;
    logic [1:0] widx;
    gate_t      gd;
    ctx_t       cx;
    logic       flt_q;
    flt_e       flt;
    logic       do_switch;

    cg_gate_check u_chk (
        .present   (gd.present),
        .dpl       (gd.dpl),
        .kind      (gd.kind),
        .tgt       (gd.csel[1:0]),
        .cpl       (cx.ocs[1:0]),
        .flt       (flt),
        .do_switch (do_switch)
    );

    cg_mem_drive u_drv (
        .st    (st),
        .ph    (ph),
        .widx  (widx),
        .cx    (cx),
        .req   (mem_req),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata)
    );

    assign busy  = (st != S_IDLE);
    assign done  = (st == S_FIN);
    assign fault = done && flt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            ph     <= 1'b0;
            widx   <= '0;
            gd     <= '0;
            cx     <= '0;
            flt_q  <= 1'b0;
            new_cs <= '0;
            new_ip <= '0;
            new_ss <= '0;
            new_sp <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (start) begin
                        cx.gbase <= gdt_base;
                        cx.tbase <= tss_base;
                        cx.sel   <= gate_sel;
                        cx.ocs   <= cur_cs;
                        cx.oip   <= cur_ip;
                        cx.oss   <= cur_ss;
                        cx.osp   <= cur_sp;
                        widx     <= '0;
                        ph       <= 1'b0;
                        flt_q    <= 1'b0;
                        st       <= S_DESC;
                    end
                end
                S_DESC: begin
                    ph <= !ph;
                    if (ph) begin
                        unique case (widx)
                            2'd0:    gd.entry <= mem_rdata;
                            2'd1:    gd.csel  <= mem_rdata;
                            default: begin
                                gd.present <= mem_rdata[15];
                                gd.dpl     <= mem_rdata[14:13];
                                gd.kind    <= mem_rdata[11:8];
                                gd.count   <= mem_rdata[CW-1:0];
                            end
                        endcase
                        if (widx == 2'd2)
                            st <= S_CHECK;
                        else
                            widx <= widx + 2'd1;
                    end
                end
                S_CHECK: begin
                    cx.pcnt <= gd.count;
                    cx.tgt  <= gd.csel[1:0];
                    if (flt != F_NONE) begin
                        flt_q <= 1'b1;
                        st    <= S_FIN;
                    end else if (do_switch) begin
                        st <= S_TSP;
                    end else begin
                        cx.nss <= cx.oss;
                        cx.nsp <= cx.osp;
                        st     <= S_PUSH_CS;
                    end
                end
                S_TSP: begin
                    ph <= !ph;
                    if (ph) begin
                        cx.nsp <= mem_rdata;
                        st     <= S_TSS;
                    end
                end
                S_TSS: begin
                    ph <= !ph;
                    if (ph) begin
                        cx.nss <= mem_rdata;
                        st     <= S_PUSH_OSS;
                    end
                end
                S_PUSH_OSS: begin
                    cx.nsp <= cx.nsp - word_t'(STEP);
                    st     <= S_PUSH_OSP;
                end
                S_PUSH_OSP: begin
                    cx.nsp <= cx.nsp - word_t'(STEP);
                    st     <= (cx.pcnt != '0) ? S_PREAD : S_PUSH_CS;
                end
                S_PREAD: begin
                    ph <= !ph;
                    if (ph) begin
                        cx.tmp <= mem_rdata;
                        st     <= S_PWRITE;
                    end
                end
                S_PWRITE: begin
                    cx.nsp  <= cx.nsp - word_t'(STEP);
                    cx.pcnt <= cx.pcnt - 1'b1;
                    st      <= (cx.pcnt == 1) ? S_PUSH_CS : S_PREAD;
                end
                S_PUSH_CS: begin
                    cx.nsp <= cx.nsp - word_t'(STEP);
                    st     <= S_PUSH_IP;
                end
                S_PUSH_IP: begin
                    cx.nsp <= cx.nsp - word_t'(STEP);
                    new_cs <= gd.csel;
                    new_ip <= gd.entry;
                    new_ss <= cx.nss;
                    new_sp <= cx.nsp - word_t'(STEP);
                    st     <= S_FIN;
                end
                S_FIN: st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // R9: completion lasts exactly one cycle and returns the block to idle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R9: the memory port stays quiet while idle
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    // R2: the first access of every call reads gate word 0 of the selected entry
    a_r2_first_read: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (mem_req && !mem_we &&
            mem_addr == $past(gdt_base) + (addr_t'($past(gate_sel) >> 3) << 3)));

    // R3: a refused call leaves every result output untouched
    a_r3_fault_holds: assert property (@(posedge clk) disable iff (rst)
        fault |-> ($stable(new_cs) && $stable(new_ip) && $stable(new_ss) && $stable(new_sp)));

    // R6: every push lowers the new stack pointer by one word
    a_r6_push_step: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |=> (cx.nsp == $past(cx.nsp) - word_t'(STEP)));

    // R3: no write is issued for a call that ends in a fault
    a_r3_no_write_on_fault: assert property (@(posedge clk) disable iff (rst)
        (st == S_CHECK && flt != F_NONE) |=> !mem_we);
endmodule

// File: tb/cg_call_gate_test.sv
`timescale 1ns/1ps
module cg_call_gate_test;
    localparam int GDT = 'h01000;
    localparam int TSS = 'h02000;
    localparam int OSS = 'h4000;
    localparam int OSP = 'h0100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] gate_sel = '0, cur_cs = '0, cur_ip = '0, cur_ss = '0, cur_sp = '0;
    logic [19:0] gdt_base = 20'(GDT), tss_base = 20'(TSS);
    logic        mem_req, mem_we, busy, done, fault;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata = '0;
    logic [15:0] new_cs, new_ip, new_ss, new_sp;

    int total = 0, bad = 0;
    bit finished = 0;
    int exp_cs = 0, exp_ip = 0, exp_ss = 0, exp_sp = 0;

    logic [15:0] mem [int];
    int    qa[$];
    int    qd[$];
    bit    qw[$];
    string qt[$];

    always #2 clk = ~clk;

    cg_call_gate uut (
        .clk(clk), .rst(rst), .start(start), .gate_sel(gate_sel),
        .cur_cs(cur_cs), .cur_ip(cur_ip), .cur_ss(cur_ss), .cur_sp(cur_sp),
        .gdt_base(gdt_base), .tss_base(tss_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fault(fault),
        .new_cs(new_cs), .new_ip(new_ip), .new_ss(new_ss), .new_sp(new_sp)
    );

    function automatic int rd(int a);
        if (mem.exists(a)) return int'(mem[a]);
        return 0;
    endfunction

    function automatic int blin(int seg, int off);
        return ((seg << 4) + off) & 'hFFFFF;
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    always @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0;
        if (mem_req && mem_we) mem[int'(mem_addr)] = mem_wdata;
    end

    // per-cycle comparison of memory traffic against the predicted access list
    always @(negedge clk) begin
        if (!rst && mem_req) begin
            if (qa.size() == 0) begin
                chk(1'b0, "R6", "unexpected access", int'(mem_addr), -1);
            end else begin
                int a, d; bit w; string t;
                a = qa.pop_front(); d = qd.pop_front(); w = qw.pop_front(); t = qt.pop_front();
                chk(mem_we == w, t, "access kind", int'(mem_we), int'(w));
                chk(int'(mem_addr) == a, t, "access address", int'(mem_addr), a);
                if (w) chk(int'(mem_wdata) == d, t, "write data", int'(mem_wdata), d);
            end
        end
    end

    task automatic exp_rd(int a, string t);
        qa.push_back(a); qd.push_back(0); qw.push_back(1'b0); qt.push_back(t);
    endtask

    task automatic exp_push(int seg, inout int sp, input int v, input string t);
        sp = (sp - 2) & 'hFFFF;
        qa.push_back(blin(seg, sp)); qd.push_back(v & 'hFFFF); qw.push_back(1'b1); qt.push_back(t);
    endtask

    task automatic set_gate(int idx, int entry, int csel, int cnt, int kind, int dpl, int p);
        int b;
        b = GDT + idx * 8;
        mem[b]     = 16'(entry);
        mem[b + 2] = 16'(csel);
        mem[b + 4] = 16'((p << 15) | (dpl << 13) | (kind << 8) | cnt);
        mem[b + 6] = 16'h0;
    endtask

    task automatic do_call(int sel, int cs, int ip, int ss, int sp, bit poke, string lbl);
        int d, w0, w1, w2, cpl, dpl, tgt, kind, cnt, nss, nsp, lat, cyc, ta;
        bit p, flt;
        d = GDT + (sel >> 3) * 8;
        w0 = rd(d); w1 = rd(d + 2); w2 = rd(d + 4);
        exp_rd(d, "R2"); exp_rd(d + 2, "R2"); exp_rd(d + 4, "R2");
        p = ((w2 >> 15) & 1) != 0;
        dpl = (w2 >> 13) & 3; kind = (w2 >> 8) & 15; cnt = w2 & 31;
        cpl = cs & 3; tgt = w1 & 3;
        flt = !p || kind != 4 || cpl > dpl || tgt > cpl;
        if (flt) begin
            lat = 8;
        end else if (tgt == cpl) begin
            nss = ss; nsp = sp;
            exp_push(nss, nsp, cs, "R4");
            exp_push(nss, nsp, ip, "R4");
            lat = 10;
        end else begin
            ta = TSS + 2 + 4 * tgt;
            exp_rd(ta, "R5"); exp_rd(ta + 2, "R5");
            nsp = rd(ta); nss = rd(ta + 2);
            exp_push(nss, nsp, ss, "R6");
            exp_push(nss, nsp, sp, "R6");
            for (int i = cnt - 1; i >= 0; i--) begin
                exp_rd(blin(ss, sp + 2 * i), "R7");
                exp_push(nss, nsp, rd(blin(ss, sp + 2 * i)), "R7");
            end
            exp_push(nss, nsp, cs, "R6");
            exp_push(nss, nsp, ip, "R6");
            lat = 16 + 3 * cnt;
        end
        if (!flt) begin
            exp_cs = w1; exp_ip = w0; exp_ss = nss; exp_sp = nsp;
        end
        gate_sel = 16'(sel); cur_cs = 16'(cs); cur_ip = 16'(ip); cur_ss = 16'(ss); cur_sp = 16'(sp);
        start = 1'b1;
        cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) start = 1'b0;
            if (poke && cyc == 3) begin start = 1'b1; gate_sel = 16'h0028; cur_cs = 16'h0031; end
            if (poke && cyc == 4) start = 1'b0;
            if (done || cyc > 400) break;
        end
        chk(cyc == lat, "R10", {lbl, " latency"}, cyc, lat);
        chk(fault == flt, flt ? "R3" : "R8", {lbl, " fault flag"}, int'(fault), int'(flt));
        chk(int'(new_cs) == exp_cs, flt ? "R3" : "R8", {lbl, " new_cs"}, int'(new_cs), exp_cs);
        chk(int'(new_ip) == exp_ip, flt ? "R3" : "R8", {lbl, " new_ip"}, int'(new_ip), exp_ip);
        chk(int'(new_ss) == exp_ss, flt ? "R3" : "R8", {lbl, " new_ss"}, int'(new_ss), exp_ss);
        chk(int'(new_sp) == exp_sp, flt ? "R3" : "R8", {lbl, " new_sp"}, int'(new_sp), exp_sp);
        chk(qa.size() == 0, "R6", {lbl, " accesses left"}, qa.size(), 0);
        qa.delete(); qd.delete(); qw.delete(); qt.delete();
        @(negedge clk);
        chk(!done && !busy, "R9", {lbl, " done one cycle"}, int'(done) * 2 + int'(busy), 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // task-state block: ring r SP at +2+4r, SS at +4+4r
        mem[TSS + 2] = 16'h0800; mem[TSS + 4]  = 16'h3000;
        mem[TSS + 6] = 16'h0600; mem[TSS + 8]  = 16'h3400;
        mem[TSS + 10] = 16'h0400; mem[TSS + 12] = 16'h3800;
        for (int i = 0; i < 32; i++) mem[blin(OSS, OSP + 2 * i)] = 16'hA000 + 16'(i);
        set_gate(1, 'h1234, 'h0008, 3,  4,   3, 1);
        set_gate(2, 'h2000, 'h0011, 0,  4,   3, 1);
        set_gate(3, 'h3000, 'h0018, 31, 4,   2, 1);
        set_gate(4, 'h4000, 'h0029, 2,  4,   1, 1);
        set_gate(5, 'h5000, 'h0008, 1,  4,   3, 0);
        set_gate(6, 'h6000, 'h0008, 1,  'hC, 3, 1);
        set_gate(7, 'h7000, 'h0008, 1,  4,   2, 1);
        set_gate(8, 'h8000, 'h0033, 1,  4,   3, 1);
        set_gate(9, 'h9000, 'h0009, 1,  4,   2, 1);

        repeat (3) @(negedge clk);
        chk(!busy && !done && !fault && !mem_req, "R1", "reset flags", int'(busy), 0);
        chk(new_cs == 0 && new_ip == 0 && new_ss == 0 && new_sp == 0, "R1", "reset outputs", int'(new_sp), 0);
        rst = 1'b0;
        @(negedge clk);

        do_call('h000B, 'h001B, 'h0111, OSS, OSP, 1'b0, "R6 R7 ring3 to ring0 three args");
        do_call('h0013, 'h001B, 'h0222, OSS, OSP, 1'b0, "R5 ring3 to ring1 no args");
        do_call('h001A, 'h0022, 'h0333, OSS, OSP, 1'b0, "R7 ring2 to ring0 31 args");
        do_call('h0021, 'h0031, 'h0444, OSS, OSP, 1'b0, "R4 same ring");
        do_call('h0028, 'h001B, 'h0555, OSS, OSP, 1'b0, "R3 absent gate");
        do_call('h0030, 'h001B, 'h0666, OSS, OSP, 1'b0, "R11 wide gate type");
        do_call('h0038, 'h001B, 'h0777, OSS, OSP, 1'b0, "R3 caller less trusted than gate");
        do_call('h0040, 'h0022, 'h0888, OSS, OSP, 1'b0, "R3 outward target");
        do_call('h0048, 'h0022, 'h0999, OSS, OSP, 1'b1, "R9 start ignored while busy");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule